// File: doc/BRIEF.md
# Start-of-Packet Gated Receive FIFO

This block is a single-clock packet buffer on the receive side of a packet link. Every stored word carries its payload together with two tags, start-of-packet and end-of-packet. At the default 32-bit width, one stored word holds a quarter of a flow-control credit. At a 64-bit width it holds half a credit. The buffer is 510 words deep by default. Reads are taken in order, and each returned word is marked with a valid strobe.

After a reset, the write side runs a two-state machine.

- **SEEK**: the state entered on reset. Every incoming word is thrown away until a word tagged start-of-packet arrives.
- **PASS**: entered on that start-of-packet word, which is itself stored. From then on every valid word is stored.

There are two ways back to SEEK:

- **Full reset** (`rst_n`): asynchronous, and restarts the whole block.
- **Buffer-only clear** (`buf_clr_n`): synchronous. It empties the storage and the write-side state machine. It does not touch any framing logic outside this block.

An active-low almost-empty flag warns the reader when exactly one word is left.

Top module: `pkt_rx_fifo`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `empty`=1, `almost_empty_n`=1, `rd_vld`=0 and `ovf`=0.
- R2: In state SEEK, a valid word with `wr_sop`=0 is discarded and never appears at the read port. Both `rst_n` and `buf_clr_n` put the write gate in SEEK.
- R3: The transition SEEK->PASS is taken on a valid word with `wr_sop`=1, and that word is stored. In PASS, every valid word is stored whatever its tags are, until the next reset or clear.
- R4: A read with `rd_en`=1 while the buffer holds data returns the oldest word, with its `rd_sop` and `rd_eop` tags, on `rd_data` with `rd_vld`=1 one cycle later. Words come out in the order they were stored.
- R5: A read request while the buffer is empty gives `rd_vld`=0 in the next cycle and does not change the occupancy.
- R6: A write that would be stored while the occupancy equals DEPTH is dropped, even if a read happens in the same cycle. `ovf` is then high for exactly the following cycle.
- R7: A stored write and a successful read in the same cycle leave the occupancy unchanged.
- R8: `empty` is 1 exactly when the occupancy is zero. It rises in the cycle after the last word is read.
- R9: `almost_empty_n` is 0 exactly when one word is stored. It falls after the read of the second-to-last word and returns to 1 once the occupancy is above one or at zero.
- R10: `buf_clr_n`=0 at a clock edge empties the buffer and clears `rd_vld` and `ovf`. Reads and writes in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| buf_clr_n | input | 1 | Synchronous active-low buffer-only clear |
| wr_vld | input | 1 | Write word valid |
| wr_data | input | DATA_W | Write payload |
| wr_sop | input | 1 | Start-of-packet tag of the write word |
| wr_eop | input | 1 | End-of-packet tag of the write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read payload |
| rd_sop | output | 1 | Start-of-packet tag of the read word |
| rd_eop | output | 1 | End-of-packet tag of the read word |
| rd_vld | output | 1 | Read word valid, one cycle after the request |
| empty | output | 1 | Buffer holds no word |
| almost_empty_n | output | 1 | Active low: exactly one word stored |
| ovf | output | 1 | One-cycle pulse after a write dropped on a full buffer |

## Verification
Most internal faults show at the ports within one or two cycles:

- **Wrong gate state**: a stray word appears on the next read, or an expected word is missing on the next read.
- **Wrong occupancy**: `empty` or `almost_empty_n` is wrong in the very next cycle, or `ovf` fires at the wrong fill level.
- **Pointer error**: a word arrives out of order or corrupted at the first read past the wrap point.

The bench runs a small six-word configuration and checks flags, pulses and data against an arithmetic queue model on every cycle. It sweeps each fill level with simultaneous traffic, then runs a long pseudo-random stream with interleaved clears and resets.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    typedef enum logic {
        GATE_SEEK = 1'b0,
        GATE_PASS = 1'b1
    } gate_e;
endpackage

// File: rtl/pkt_rx_gate.sv
module pkt_rx_gate
    import pkt_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  wr_vld,
    input  logic  wr_sop,
    output logic  accept,
    output gate_e state
);
    gate_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= GATE_SEEK;
        else if (clr) state <= GATE_SEEK;
        else          state <= nxt;
    end

    // next state and acceptance
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            GATE_SEEK: begin
                accept = wr_vld && wr_sop;
                if (accept) nxt = GATE_PASS;
            end
            GATE_PASS: begin
                accept = wr_vld;
            end
            default: nxt = GATE_SEEK;
        endcase
    end
endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store #(
    parameter int WORD_W = 34,
    parameter int DEPTH  = 510,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_word,
    output logic              pop_vld,
    output logic [CW-1:0]     count,
    output logic              ovf
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, is_empty, do_push, do_pop;

    assign full     = (count == FULLC);
    assign is_empty = (count == '0);
    assign do_push  = push && !full && !clr;
    assign do_pop   = pop && !is_empty && !clr;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            pop_vld  <= 1'b0;
            pop_word <= '0;
            ovf      <= 1'b0;
        end else if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            pop_vld <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            ovf     <= push && full;
            pop_vld <= do_pop;
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop) begin
                pop_word <= mem[rd_ptr];
                rd_ptr   <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 510
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr_n,
    input  logic              wr_vld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_vld,
    output logic              empty,
    output logic              almost_empty_n,
    output logic              ovf
);
    localparam int WORD_W = DATA_W + 2;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              clr, accept;
    gate_e             gate_st;
    logic [CW-1:0]     fill_cnt;
    logic [WORD_W-1:0] out_word;

    assign clr = !buf_clr_n;

    pkt_rx_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_vld (wr_vld),
        .wr_sop (wr_sop),
        .accept (accept),
        .state  (gate_st)
    );

    pkt_rx_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (accept),
        .push_word ({wr_sop, wr_eop, wr_data}),
        .pop       (rd_en),
        .pop_word  (out_word),
        .pop_vld   (rd_vld),
        .count     (fill_cnt),
        .ovf       (ovf)
    );

    assign rd_sop         = out_word[WORD_W-1];
    assign rd_eop         = out_word[WORD_W-2];
    assign rd_data        = out_word[DATA_W-1:0];
    assign empty          = (fill_cnt == '0);
    assign almost_empty_n = (fill_cnt != CW'(1));
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 510,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          buf_clr_n,
    input logic          wr_vld,
    input logic          wr_sop,
    input logic          rd_en,
    input logic          rd_vld,
    input logic          empty,
    input logic          almost_empty_n,
    input logic          ovf,
    input logic [CW-1:0] cnt,
    input gate_e         gate_st
);
    AST_EMPTY_NOT_AE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty_n); // R9

    AST_RDVLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_en && !empty && buf_clr_n)); // R4

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(wr_vld && cnt == CW'(DEPTH) && buf_clr_n)); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_clr_n |=> (empty && !rd_vld && !ovf)); // R10

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_clr_n && gate_st == GATE_PASS && wr_vld && rd_en && !empty
         && cnt != CW'(DEPTH)) |=> $stable(cnt)); // R7

    AST_SEEK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_st == GATE_SEEK && wr_vld && !wr_sop && !(rd_en && !empty))
        |=> $stable(cnt)); // R2
endmodule

bind pkt_rx_fifo pkt_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .buf_clr_n      (buf_clr_n),
    .wr_vld         (wr_vld),
    .wr_sop         (wr_sop),
    .rd_en          (rd_en),
    .rd_vld         (rd_vld),
    .empty          (empty),
    .almost_empty_n (almost_empty_n),
    .ovf            (ovf),
    .cnt            (fill_cnt),
    .gate_st        (gate_st)
);

// File: tb/sim_pkt_rx_fifo.sv
`timescale 1ns/1ps
module sim_pkt_rx_fifo;
    localparam int DW = 8;
    localparam int DP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0, buf_clr_n = 1'b1;
    logic wr_vld = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_sop, rd_eop, rd_vld, empty, almost_empty_n, ovf;

    always #10 clk = ~clk;

    pkt_rx_fifo #(.DATA_W(DW), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .buf_clr_n(buf_clr_n),
        .wr_vld(wr_vld), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .rd_en(rd_en), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
        .rd_vld(rd_vld), .empty(empty), .almost_empty_n(almost_empty_n), .ovf(ovf)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [DW+1:0] q[$];
    bit seek = 1'b1;
    logic [DW+1:0] exp_word = '0;
    bit exp_vld = 1'b0, exp_ovf = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        chk(empty == (q.size() == 0), {tag, " R8 empty"}, empty, q.size() == 0);
        chk(almost_empty_n == (q.size() != 1), {tag, " R9 almost_empty_n"}, almost_empty_n, q.size() != 1);
        chk(ovf == exp_ovf, {tag, " R6 ovf"}, ovf, exp_ovf);
        chk(rd_vld == exp_vld, {tag, " R4/R5 rd_vld"}, rd_vld, exp_vld);
        if (exp_vld && rd_vld)
            chk({rd_sop, rd_eop, rd_data} == exp_word, {tag, " R4 word"}, {rd_sop, rd_eop, rd_data}, exp_word);
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic step(input bit wv, input bit s, input bit e, input logic [DW-1:0] d,
                        input bit re, input bit clr, input string tag);
        bit acc, full;
        wr_vld = wv; wr_sop = s; wr_eop = e; wr_data = d; rd_en = re; buf_clr_n = !clr;
        @(posedge clk);
        if (clr) begin
            q.delete(); seek = 1'b1; exp_vld = 1'b0; exp_ovf = 1'b0;     // R10
        end else begin
            full = (q.size() == DP);
            acc = wv && (!seek || s);                                      // R2 R3
            if (acc) seek = 1'b0;
            exp_vld = re && (q.size() != 0);                               // R5
            if (exp_vld) exp_word = q.pop_front();
            exp_ovf = acc && full;                                         // R6
            if (acc && !full) q.push_back({s, e, d});                      // R7
        end
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic full_reset();
        wr_vld = 0; rd_en = 0; buf_clr_n = 1;
        rst_n = 1'b0;
        @(negedge clk);
        q.delete(); seek = 1'b1; exp_vld = 0; exp_ovf = 0;
        check_outs("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 after reset");
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        @(negedge clk);
        full_reset();
        // R2: words without SOP discarded after reset
        for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h10 + 8'(i), 0, 0, "R2 drop");
        step(0, 0, 0, 0, 1, 0, "R5 read empty");
        // R3: SOP accepted, then everything; overfill by 2 (R6)
        step(1, 1, 0, 8'hA0, 0, 0, "R3 sop");
        for (int i = 1; i < DP + 2; i++) step(1, 0, (i == DP + 1), 8'hA0 + 8'(i), 0, 0, "R6 fill");
        // R6: write on full with simultaneous read still dropped
        step(1, 0, 0, 8'hEE, 1, 0, "R6 full rw");
        for (int i = 0; i < DP + 1; i++) step(0, 0, 0, 0, 1, 0, "R4 drain");
        // R10: clear mid-stream, then R2 again
        step(1, 1, 0, 8'h31, 0, 0, "R3 sop2");
        step(1, 0, 0, 8'h32, 0, 0, "R3 body");
        step(1, 1, 0, 8'h33, 1, 1, "R10 clear");
        step(1, 0, 1, 8'h34, 1, 0, "R2 after clear");
        step(0, 0, 0, 0, 1, 0, "R10 empty");
        // sweep every fill level with a simultaneous read+write (R7 R9)
        for (int n = 0; n <= DP; n++) begin
            step(0, 0, 0, 0, 0, 1, "sweep clr");
            for (int k = 0; k < n; k++) step(1, (k == 0), 0, 8'(16 * n + k), 0, 0, "R3 sweep fill");
            step(1, (n == 0), 1, 8'hC0 + 8'(n), 1, 0, "R7 sweep rw");
            for (int k = 0; k <= n + 1; k++) step(0, 0, 0, 0, 1, 0, "R9 sweep drain");
        end
        // full reset while data held returns to SEEK
        step(1, 1, 0, 8'h55, 0, 0, "R3 pre-reset");
        full_reset();
        step(1, 0, 0, 8'h56, 0, 0, "R2 post reset");
        step(0, 0, 0, 0, 1, 0, "R2 post reset read");
        // pseudo-random stream
        for (int i = 0; i < 3000; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4], lfsr[15:8],
                 lfsr[5] & (lfsr[6] | lfsr[7]), (lfsr[15:9] == 7'h55), "R4 random");
            if (lfsr[14:2] == 13'h0ABC) full_reset();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule